// File: doc/BRIEF.md
# Memory Stack Mapping Analyzer

This block picks the address bits that select one of four memory stacks. It watches a small sample of offloadable code instances, typically around a tenth of a percent of them. For every instance it records which stacks the addresses would reach under each candidate mapping. The candidate mappings are ten two-bit fields of consecutive address bits, with low bits 7 through 16. Bit 7 is the lowest because a cache line is 128 bytes.

All ten candidates are scored in parallel, one address per cycle. The score of a candidate is the number of distinct stacks each instance touches, summed over the sample. A lower score means better co-location. Once the programmed number of instances has been seen, the block registers the winning low bit position and raises a done flag. Both hold until reset, so the choice is fixed before any bulk data copy uses it.

Top module: `stack_map_analyzer`

## Requirements
- R1: In reset and on the first cycle after it, `map_done` is 0 and `best_pos` is 7.
- R2: Candidate k (k = 0..9) takes address bits [8+k:7+k] as a stack number 0..3. For each instance, it adds to its total the number of distinct stack numbers among that instance's accepted addresses.
- R3: An instance ends on an accepted `inst_end`, and each such cycle counts one instance. The cycle after the count first equals `sample_target`, `map_done` goes to 1. At the same time `best_pos` shows 7+k, where k is the candidate with the smallest total.
- R4: When several candidates share the smallest total, the one with the lowest bit position is reported.
- R5: An accepted `inst_start` throws away the stacks gathered since the last instance end. An address in the same cycle as `inst_start` belongs to the new instance, and an address in the same cycle as `inst_end` belongs to the instance that is ending.
- R6: While `sample_en` is 0, addresses and markers have no effect on the totals or the instance count.
- R7: Once `map_done` is 1, it and `best_pos` hold their values until reset, whatever the inputs do.
- R8: Each candidate total saturates at 2^ACC_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Enables sampling of addresses and markers |
| sample_target | input | CNT_W | Number of instances to analyse; held stable while sampling |
| addr_vld | input | 1 | `addr` carries an access this cycle |
| addr | input | ADDR_W | Accessed byte address |
| inst_start | input | 1 | First cycle of an instance |
| inst_end | input | 1 | Last cycle of an instance |
| best_pos | output | POS_W | Low bit position of the chosen two-bit stack field |
| map_done | output | 1 | Result is valid and frozen |

## Verification
Hand-built instances whose addresses differ in chosen bits separate the candidates one by one. Addresses that differ only in bit 7 make every candidate except the lowest tie, which tests the tie rule. Addresses that differ in bits 7..15 leave only the top field clean. A long run of pseudo-random addresses, compared with a behavioural model on every clock, covers the general scoring. Targeted sequences cover the remaining rules: an instance aborted by a restart, input while sampling is off, input after the result is frozen, and a total driven past the saturation point where a wrapping counter would pick a different winner.

// File: rtl/smap_pkg.sv
package smap_pkg;

  typedef enum logic {
    ST_SAMPLE = 1'b0,
    ST_HOLD   = 1'b1
  } smap_state_e;

endpackage

// File: rtl/smap_lane.sv
module smap_lane #(
  parameter int ADDR_W = 40,
  parameter int SEL_W  = 2,
  parameter int LOW    = 7,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              start,
  input  logic              fin,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int NSTK = 1 << SEL_W;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [NSTK-1:0]  mask_q;
  logic [NSTK-1:0]  base, hit, merged;
  logic [SEL_W-1:0] stack;
  logic [SEL_W:0]   nstk_hit;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_q;

  assign stack  = addr[LOW +: SEL_W];
  assign hit    = addr_vld ? (NSTK'(1) << stack) : '0;
  assign base   = start ? '0 : mask_q;
  assign merged = base | hit;

  always_comb begin
    nstk_hit = '0;
    for (int i = 0; i < NSTK; i++) nstk_hit = nstk_hit + (SEL_W+1)'(merged[i]);
  end

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(nstk_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      acc_q  <= '0;
    end else if (accept) begin
      if (fin) begin
        mask_q <= '0;
        acc_q  <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
      end else begin
        mask_q <= merged;
      end
    end
  end

  assign acc_o = acc_q;

  // R5: mask is empty after an instance closes
  assert_mask_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && fin) |=> (mask_q == '0));

  // R8: total never decreases outside reset (saturation, no wrap)
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (acc_q >= $past(acc_q)));

  // R6: nothing changes while input is not accepted
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(acc_q) && $stable(mask_q)));

endmodule

// File: rtl/smap_argmin.sv
module smap_argmin #(
  parameter int NUM_CAND = 10,
  parameter int ACC_W    = 16,
  parameter int IDX_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CAND*ACC_W-1:0] acc_flat,
  output logic [IDX_W-1:0]          best_idx
);
  logic [ACC_W-1:0] best_val;
  logic [ACC_W-1:0] acc_of [NUM_CAND];

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_unpack
    assign acc_of[g] = acc_flat[g*ACC_W +: ACC_W];
  end

  always_comb begin
    best_idx = '0;
    best_val = acc_of[0];
    for (int i = 1; i < NUM_CAND; i++) begin
      if (acc_of[i] < best_val) begin
        best_val = acc_of[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_chk
    // R3: chosen total is no larger than any other
    assert_min_R3: assert property (@(posedge clk) disable iff (rst)
      acc_of[best_idx] <= acc_flat[g*ACC_W +: ACC_W]);
    // R4: every lower position has a strictly larger total
    assert_tie_low_R4: assert property (@(posedge clk) disable iff (rst)
      (IDX_W'(g) < best_idx) |-> (acc_flat[g*ACC_W +: ACC_W] > acc_of[best_idx]));
  end

endmodule

// File: rtl/smap_ctrl.sv
module smap_ctrl
  import smap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 4,
  parameter int LOW   = 7,
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic [CNT_W-1:0] target,
  input  logic             inst_end,
  input  logic [IDX_W-1:0] best_idx,
  output logic             accept,
  output logic [POS_W-1:0] best_pos,
  output logic             done
);
  smap_state_e      state_q;
  logic [CNT_W-1:0] count_q;
  logic [POS_W-1:0] pos_q;
  logic             reached;

  assign reached = (count_q >= target);
  assign accept  = sample_en && (state_q == ST_SAMPLE) && !reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SAMPLE;
      count_q <= '0;
      pos_q   <= POS_W'(LOW);
    end else begin
      if (accept && inst_end) count_q <= count_q + 1'b1;
      if (state_q == ST_SAMPLE && reached) begin
        state_q <= ST_HOLD;
        pos_q   <= POS_W'(LOW) + POS_W'(best_idx);
      end
    end
  end

  assign done     = (state_q == ST_HOLD);
  assign best_pos = pos_q;

  // R7: done is sticky
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R7: result frozen once done
  assert_pos_hold_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(best_pos));
  // R3: done only rises after enough instances
  assert_done_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (count_q >= target));
  // R6: instance count only moves on accepted markers
  assert_count_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !(accept && inst_end) |=> $stable(count_q));

endmodule

// File: rtl/stack_map_analyzer.sv
module stack_map_analyzer #(
  parameter int ADDR_W   = 40,
  parameter int SEL_W    = 2,
  parameter int LOW_BIT  = 7,
  parameter int NUM_CAND = 10,
  parameter int ACC_W    = 16,
  parameter int CNT_W    = 16,
  localparam int POS_W   = $clog2(LOW_BIT + NUM_CAND),
  localparam int IDX_W   = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic [CNT_W-1:0]  sample_target,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic              inst_start,
  input  logic              inst_end,
  output logic [POS_W-1:0]  best_pos,
  output logic              map_done
);
  logic                      accept;
  logic [NUM_CAND*ACC_W-1:0] acc_flat;
  logic [IDX_W-1:0]          best_idx;

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_lane
    smap_lane #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LOW(LOW_BIT + k), .ACC_W(ACC_W)
    ) i_lane (
      .clk     (clk),
      .rst     (rst),
      .accept  (accept),
      .start   (inst_start),
      .fin     (inst_end),
      .addr_vld(addr_vld),
      .addr    (addr),
      .acc_o   (acc_flat[k*ACC_W +: ACC_W])
    );
  end

  smap_argmin #(
    .NUM_CAND(NUM_CAND), .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) i_argmin (
    .clk     (clk),
    .rst     (rst),
    .acc_flat(acc_flat),
    .best_idx(best_idx)
  );

  smap_ctrl #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .LOW(LOW_BIT), .POS_W(POS_W)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sample_en(sample_en),
    .target   (sample_target),
    .inst_end (inst_end),
    .best_idx (best_idx),
    .accept   (accept),
    .best_pos (best_pos),
    .done     (map_done)
  );

  // R1: reset values
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!map_done && best_pos == POS_W'(LOW_BIT)));
  // R3: reported position lies inside the candidate range
  assert_range_R3: assert property (@(posedge clk) disable iff (rst)
    map_done |-> (best_pos >= POS_W'(LOW_BIT) && best_pos <= POS_W'(LOW_BIT + NUM_CAND - 1)));

endmodule

// File: tb/test_stack_map_analyzer.sv
module test_stack_map_analyzer;
  localparam int ACC_W = 8;
  localparam int NC    = 10;
  localparam int LOWB  = 7;

  logic        clk = 0;
  logic        rst = 1;
  logic        sample_en = 0;
  logic [15:0] sample_target = 16'd1;
  logic        addr_vld = 0;
  logic [39:0] addr = '0;
  logic        inst_start = 0, inst_end = 0;
  logic [4:0]  best_pos;
  logic        map_done;

  always #4 clk = ~clk;

  stack_map_analyzer #(.ACC_W(ACC_W)) i_stack_map_analyzer (
    .clk(clk), .rst(rst), .sample_en(sample_en), .sample_target(sample_target),
    .addr_vld(addr_vld), .addr(addr), .inst_start(inst_start), .inst_end(inst_end),
    .best_pos(best_pos), .map_done(map_done)
  );

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit started = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_mask[NC];
  int m_acc[NC];
  int m_cnt, m_best;
  bit m_done;

  function automatic int popc(input int v);
    int c = 0;
    for (int i = 0; i < 4; i++) c += (v >> i) & 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NC; k++) begin m_mask[k] = 0; m_acc[k] = 0; end
      m_cnt = 0; m_done = 0; m_best = LOWB;
    end else begin
      bit act;
      act = sample_en && !m_done && (m_cnt < int'(sample_target));
      if (!m_done && m_cnt >= int'(sample_target)) begin
        int b;
        b = 0;
        for (int k = 1; k < NC; k++) if (m_acc[k] < m_acc[b]) b = k;
        m_done = 1; m_best = LOWB + b;
      end
      if (act) begin
        for (int k = 0; k < NC; k++) begin
          if (inst_start) m_mask[k] = 0;
          if (addr_vld) m_mask[k] |= 1 << int'((addr >> (LOWB + k)) & 40'd3);
          if (inst_end) begin
            m_acc[k] += popc(m_mask[k]);
            if (m_acc[k] > (1 << ACC_W) - 1) m_acc[k] = (1 << ACC_W) - 1;
            m_mask[k] = 0;
          end
        end
        if (inst_end) m_cnt++;
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      chk({phase, " done"}, int'(map_done), int'(m_done));
      chk({phase, " best_pos"}, int'(best_pos), m_best);
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      addr_vld = 0; inst_start = 0; inst_end = 0;
    end
  endtask

  task automatic do_reset(input int target);
    @(negedge clk);
    rst = 1; sample_en = 0; addr_vld = 0; inst_start = 0; inst_end = 0;
    sample_target = 16'(target);
    idle(2);
    rst = 0;
  endtask

  task automatic inst4(input logic [39:0] a0, a1, a2, a3, input int n);
    logic [39:0] a [4];
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addr_vld = 1; addr = a[i]; inst_start = (i == 0); inst_end = (i == n - 1);
    end
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    phase = "R1";
    idle(3);
    chk("R1 done in reset", int'(map_done), 0);
    rst = 0; sample_en = 0;
    @(negedge clk);
    chk("R1 done after reset", int'(map_done), 0);
    chk("R1 best_pos after reset", int'(best_pos), 7);

    // R4: differ only in bit 7 -> candidate 0 worst, others tie -> 8
    phase = "R4";
    do_reset(3); sample_en = 1;
    repeat (3) inst4(40'h0, 40'h80, 40'h0, 40'h0, 2);
    idle(2);
    chk("R4 done", int'(map_done), 1);
    chk("R4 tie to lowest", int'(best_pos), 8);

    // R3: differ in bits 7..15 -> only bits 17:16 clean -> 16
    phase = "R3";
    do_reset(2); sample_en = 1;
    repeat (2) inst4(40'h0, 40'hFF80, 40'h0, 40'h0, 2);
    @(negedge clk);
    chk("R3 done rises one cycle after last end", int'(map_done), 1);
    chk("R3 best high field", int'(best_pos), 16);

    // R2: pseudo-random instances, model compared every cycle
    phase = "R2";
    do_reset(200); sample_en = 1;
    for (int j = 0; j < 200; j++) begin
      logic [39:0] r0, r1, r2, r3;
      int sh;
      sh = j % 12;
      r0 = {8'h0, $urandom()};
      r1 = r0 ^ (40'(($urandom() & 32'h3)) << (7 + sh));
      r2 = r0 + (40'd1 << (7 + (j % 11)));
      r3 = {$urandom(), 8'h0};
      inst4(r0, r1, r2, r3, 1 + (j % 4));
    end
    idle(2);
    chk("R2 random done", int'(map_done), 1);

    // R5: aborted instance discarded
    phase = "R5";
    do_reset(1); sample_en = 1;
    @(negedge clk); addr_vld = 1; addr = 40'h80; inst_start = 1; inst_end = 0;
    @(negedge clk); addr_vld = 1; addr = 40'h0;  inst_start = 1; inst_end = 0;
    @(negedge clk); addr_vld = 1; addr = 40'h0;  inst_start = 0; inst_end = 1;
    idle(2);
    chk("R5 abort dropped, all tie", int'(best_pos), 7);

    // R6: input with sample_en low ignored
    phase = "R6";
    do_reset(1); sample_en = 0;
    repeat (3) inst4(40'h0, 40'h80, 40'h0, 40'h0, 2);
    idle(2);
    chk("R6 no instance counted", int'(map_done), 0);
    sample_en = 1;
    inst4(40'h0, 40'h0, 40'h0, 40'h0, 2);
    idle(1);
    chk("R6 done after enabled instance", int'(map_done), 1);
    chk("R6 ignored input left no score", int'(best_pos), 7);

    // R7: frozen after done
    phase = "R7";
    repeat (4) inst4(40'h0, 40'hFF80, 40'h0, 40'h0, 2);
    chk("R7 still done", int'(map_done), 1);
    chk("R7 best held", int'(best_pos), 7);

    // R8: candidate 0 passes 255; wrap would make it win (7), saturation keeps 9
    phase = "R8";
    do_reset(64); sample_en = 1;
    repeat (64) inst4(40'h0, 40'h80, 40'h100, 40'h180, 4);
    idle(2);
    chk("R8 done", int'(map_done), 1);
    chk("R8 saturation keeps winner", int'(best_pos), 9);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule